// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives a 10-bit successive-approximation converter. The host raises `start_req` for one clock to request a conversion. If `acq_sel` is not zero, the sequencer first holds the sampling switch closed for that many conversion-clock periods (TAD). It then opens the switch and makes ten bit decisions, one per TAD, with the most significant bit first. For each decision it places a trial code on `dac_code` and reads the external comparator on `cmp_hi`.

A programmable divider derives the TAD from the system clock. When the last bit is decided, the block writes the result register, drops `busy` so that software can poll for completion, and sets an interrupt flag. The interrupt output is that flag gated by an enable. A recovery gap of three TAD then follows, and no sampling takes place during it. A start request that arrives inside the gap is held and is served as soon as the gap ends.

The host clears `en` to abort a conversion that is in progress. The previous result is kept. Every control and status pin is a plain level or a one-cycle pulse. The result is a register that the host reads at any time, so the block has no back-pressure path.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Bits are tried from the most significant bit down. A trial bit stays set when `cmp_hi` is 1, which means the input is at or above `dac_code`. With a comparator that reports vin >= `dac_code`, the stored result equals vin for every code from 000h to 3FFh. `result_hi` holds result bits 9:8 and `result_lo` holds bits 7:0.
- R2: Let D = 2 << `div_sel` system clocks per TAD and A = `acq_sel`. `busy` rises at the edge that accepts a start and falls (A+10)*D clocks later. The result updates at that same edge.
- R3: When A = 0, in the cycle after acceptance `dac_code` is 200h and `sample_on` is low. When A > 0, `dac_code` is 000h and `sample_on` is high in that cycle.
- R4: `sample_on` is high while `en` is high and the block is idle or acquiring. It is low throughout conversion, throughout recovery, and whenever `en` is low.
- R5: `int_flag` is set at completion and stays set until `flag_clr` is asserted. If completion and `flag_clr` fall in the same cycle, the set wins. `irq` is high only when both `int_flag` and `int_en` are high.
- R6: A `start_req` during acquisition or conversion is ignored. The completion time does not change, and no further conversion follows.
- R7: After completion, `sample_on` stays low for 3 TAD. A `start_req` that arrives in this gap is held. It is accepted at the first edge after the gap, so `busy` rises 3*D+1 clocks after the completion edge.
- R8: A `start_req` while `en` is low is ignored. Dropping `en` aborts any conversion: one cycle later `busy` is low and `dac_code` is 000h.
- R9: The result register changes only at completion. An abort leaves the previous value in place, and reset does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en | input | 1 | Module enable; low aborts and idles |
| start_req | input | 1 | One-cycle start request from the host |
| acq_sel | input | 3 | Acquisition length in TAD (0 = none) |
| div_sel | input | 3 | TAD = (2 << div_sel) system clocks |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| int_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear the completion flag |
| busy | output | 1 | Start/busy status; low means done |
| sample_on | output | 1 | Sampling switch closed |
| dac_code | output | 10 | Trial code for the DAC |
| result_hi | output | 2 | Result bits 9:8 |
| result_lo | output | 8 | Result bits 7:0 |
| int_flag | output | 1 | Completion flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench drives each input at a falling edge, so the accepting rising edge is the next one, and it samples outputs on later falling edges. It counts edges from acceptance until `busy` drops and compares the count with (A+10)*D. It reads the result, the flag and `sample_on` at that same falling edge. For a request held in the gap it counts 3*D+1 edges to the rise of `busy`. For the first TAD it checks `dac_code` and `sample_on` one edge after acceptance, and after an abort it checks `busy` and `dac_code` one edge after `en` falls.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_REC  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sar_tad_div.sv
// Conversion-clock tick generator: one tick every (2 << div_sel) clocks,
// phase restarted on demand so timing is counted from acceptance.
module sar_tad_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   lim;

  assign span = (CNT_W+1)'(2) << div_sel;
  assign lim  = span - 1'b1;
  assign tick = (cnt == lim[CNT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_core.sv
// Successive-approximation register with bit index.
module sar_core #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             init,
  input  logic             step,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] code,
  output logic [NBITS-1:0] kept,
  output logic             last
);
  localparam int IDX_W = $clog2(NBITS);

  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] adv;

  // kept: current bit resolved; adv: resolved plus next trial bit
  for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
    assign kept[gi] = (idx == IDX_W'(gi)) ? cmp_hi : code[gi];
    assign adv[gi]  = ((IDX_W+1)'(idx) == (IDX_W+1)'(gi + 1)) ? 1'b1 : kept[gi];
  end

  assign last = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      idx  <= '0;
    end else if (clear) begin
      code <= '0;
      idx  <= '0;
    end else if (init) begin
      code <= NBITS'(1) << (NBITS - 1);
      idx  <= IDX_W'(NBITS - 1);
    end else if (step) begin
      code <= adv;
      if (!last) idx <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/sar_irq_flag.sv
// Completion flag: set beats clear; request gated by enable.
module sar_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic int_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & int_en;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int ACQ_W   = 3,
  parameter int SEL_W   = 3,
  parameter int GAP_TAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_req,
  input  logic [ACQ_W-1:0] acq_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             cmp_hi,
  input  logic             int_en,
  input  logic             flag_clr,
  output logic             busy,
  output logic             sample_on,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-9:0] result_hi,
  output logic [7:0]       result_lo,
  output logic             int_flag,
  output logic             irq
);
  localparam int GAP_W = $clog2(GAP_TAD + 1);
  localparam int CW    = (ACQ_W > GAP_W) ? ACQ_W : GAP_W;

  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic             pend;
  logic             tick;
  logic             accept, acq_done, bit_step, finish;
  logic             sar_clear, sar_init, last;
  logic [NBITS-1:0] kept;
  logic [NBITS-1:0] result_q;

  assign accept   = en && (state == ST_IDLE) && (start_req || pend);
  assign acq_done = en && (state == ST_ACQ) && tick && (cnt == CW'(1));
  assign bit_step = en && (state == ST_CONV) && tick;
  assign finish   = bit_step && last;

  assign sar_clear = !en || (accept && (acq_sel != '0));
  assign sar_init  = (accept && (acq_sel == '0)) || acq_done;

  sar_tad_div #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .div_sel (div_sel),
    .tick    (tick)
  );

  sar_core #(.NBITS(NBITS)) u_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (sar_clear),
    .init   (sar_init),
    .step   (bit_step),
    .cmp_hi (cmp_hi),
    .code   (dac_code),
    .kept   (kept),
    .last   (last)
  );

  sar_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (finish),
    .clr    (flag_clr),
    .int_en (int_en),
    .flag   (int_flag),
    .irq    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            pend  <= 1'b0;
            cnt   <= CW'(acq_sel);
            state <= (acq_sel == '0) ? ST_CONV : ST_ACQ;
          end
        end
        ST_ACQ: begin
          if (tick) begin
            if (cnt == CW'(1)) state <= ST_CONV;
            else               cnt   <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (finish) begin
            state <= ST_REC;
            cnt   <= CW'(GAP_TAD);
          end
        end
        ST_REC: begin
          if (start_req) pend <= 1'b1;
          if (tick) begin
            if (cnt == CW'(1)) state <= ST_IDLE;
            else               cnt   <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // result register: written only at completion, not touched by reset
  always_ff @(posedge clk) begin
    if (finish) result_q <= kept;
  end

  assign result_hi = result_q[NBITS-1:8];
  assign result_lo = result_q[7:0];
  assign busy      = (state == ST_ACQ) || (state == ST_CONV);
  assign sample_on = en && ((state == ST_IDLE) || (state == ST_ACQ));
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             busy,
  input logic             sample_on,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-9:0] result_hi,
  input logic [7:0]       result_lo,
  input logic             int_flag
);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable({result_hi, result_lo}));

  // R4
  switch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (dac_code != '0)) |-> !sample_on);

  // R5
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> int_flag);

  // R7
  gap_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> !sample_on);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .busy      (busy),
  .sample_on (sample_on),
  .dac_code  (dac_code),
  .result_hi (result_hi),
  .result_lo (result_lo),
  .int_flag  (int_flag)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start_req = 1'b0;
  logic [2:0] acq_sel = '0;
  logic [2:0] div_sel = '0;
  logic       int_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       busy, sample_on, int_flag, irq, cmp_hi;
  logic [9:0] dac_code;
  logic [1:0] result_hi;
  logic [7:0] result_lo;
  logic [9:0] vin = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // comparator model: input at or above DAC level
  assign cmp_hi = (vin >= dac_code);

  sar_conv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req),
    .acq_sel(acq_sel), .div_sel(div_sel), .cmp_hi(cmp_hi),
    .int_en(int_en), .flag_clr(flag_clr), .busy(busy),
    .sample_on(sample_on), .dac_code(dac_code), .result_hi(result_hi),
    .result_lo(result_lo), .int_flag(int_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int res_val();
    return int'({result_hi, result_lo});
  endfunction

  task automatic settle(input int d);
    repeat (3 * (2 << d) + 4) @(negedge clk);
  endtask

  // one conversion; poke >= 0 re-requests start that many samples in
  task automatic do_conv(input int v, input int a, input int d, input int poke);
    int k, n, bad;
    k = (a + 10) * (2 << d);
    vin = 10'(v); acq_sel = 3'(a); div_sel = 3'(d);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    if (a == 0) begin
      chk(dac_code == 10'h200 && !sample_on, "R3 first trial", int'(dac_code), 'h200);
    end else begin
      chk(dac_code == 10'h000 && sample_on, "R3 acquisition", int'(dac_code), 0);
    end
    n = 0; bad = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      start_req = (n == poke);
      n++;
      if (busy && (sample_on != (dac_code == '0))) bad++;
    end
    start_req = 1'b0;
    chk(n == k, "R2 conversion length", n, k);
    chk(res_val() == v, "R1 result", res_val(), v);
    chk(bad == 0, "R4 switch during busy", bad, 0);
    chk(!sample_on, "R7 gap no sampling", int'(sample_on), 0);
    chk(int_flag, "R5 flag set", int'(int_flag), 1);
  endtask

  task automatic t_reset;
    chk(!busy && !int_flag && !irq, "R5 reset status", int'({busy, int_flag, irq}), 0);
    chk(!sample_on && dac_code == '0, "R4 disabled idle", int'(sample_on), 0);
    en = 1'b1;
    @(negedge clk);
    chk(sample_on, "R4 enabled idle samples", int'(sample_on), 1);
  endtask

  task automatic t_codes;
    do_conv('h155, 0, 0, -1); settle(0);
    do_conv('h3FF, 2, 1, -1); settle(1);
    do_conv('h000, 7, 0, -1); settle(0);
    do_conv('h2AA, 1, 2, -1); settle(2);
    do_conv('h200, 0, 5, -1); settle(5);
    do_conv('h1FF, 3, 3, -1); settle(3);
  endtask

  task automatic t_ignore;
    int quiet;
    // R6: re-request during acquisition and during conversion
    do_conv('h0C3, 2, 1, 3);
    quiet = 0;
    repeat (3 * 4 + 10) begin
      @(negedge clk);
      if (busy) quiet++;
    end
    chk(quiet == 0, "R6 no extra conversion", quiet, 0);
    do_conv('h31A, 1, 0, 12); settle(0);
    chk(res_val() == 'h31A, "R6 result intact", res_val(), 'h31A);
  endtask

  task automatic t_gap;
    int m;
    do_conv('h0F0, 0, 1, -1);
    start_req = 1'b1;
    m = 0;
    do begin
      @(negedge clk);
      start_req = 1'b0;
      m++;
    end while (!busy && m < 1000);
    chk(m == 3 * 4 + 1, "R7 held start latency", m, 13);
    while (busy) @(negedge clk);
    chk(res_val() == 'h0F0, "R7 held conversion result", res_val(), 'h0F0);
    settle(1);
  endtask

  task automatic t_flag;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(!int_flag, "R5 flag cleared", int'(int_flag), 0);
    int_en = 1'b0;
    do_conv('h077, 0, 0, -1);
    chk(!irq, "R5 irq masked", int'(irq), 0);
    int_en = 1'b1; #1;
    chk(irq, "R5 irq enabled", int'(irq), 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(!int_flag && !irq, "R5 clear drops irq", int'({int_flag, irq}), 0);
    settle(0);
    // completion coinciding with clear: set wins
    vin = 10'h101; acq_sel = 3'd0; div_sel = 3'd0;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (19) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk(!busy && int_flag, "R5 set beats clear", int'(int_flag), 1);
    int_en = 1'b0;
    settle(0);
  endtask

  task automatic t_disable;
    int prev;
    prev = res_val();
    en = 1'b0;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy, "R8 start ignored while disabled", int'(busy), 0);
    en = 1'b1;
    vin = 10'h2C8; acq_sel = 3'd1; div_sel = 3'd1;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (14) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!busy && dac_code == '0, "R8 abort idles", int'(dac_code), 0);
    chk(!sample_on, "R4 disabled no sampling", int'(sample_on), 0);
    chk(res_val() == prev, "R9 result kept on abort", res_val(), prev);
    en = 1'b1;
    @(negedge clk);
    do_conv('h2C8, 1, 1, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_ignore();
    t_gap();
    t_flag();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule